// File: doc/BRIEF.md
# Solenoid Driver Status and Control Register

This block is the 32-bit status and control word of an eight-channel solenoid driver. Software reaches it through a plain register port. A full-word write sets the channel-on bits, the fault masks, the switching-frequency select, the channel-pair modes and the global active bit. A separate byte-wide strobe rewrites only the channel-on byte, so that channels can be switched quickly.

Raw fault events arrive as single-cycle pulses and are latched into read-only flags. The undervoltage flag is set by reset and cleared by a read of this word. The other flags are cleared by a strobe that stands for a read of the separate fault register. The block drives an active-low fault line, the gated channel enables and the byte that the serial response carries.

Top module: `sdrv_status_reg`

## Requirements
- R1: After reset, `rd_data` reads 0x0004_0002: the communication mask (bit 18) is 1, the undervoltage flag (bit 1) is 1, and every other bit is 0. In this state `fault_n` is 0 and `ch_en` is 0.
- R2: A full write (`wr_en`) loads bits 31:24 (channel on, bit N is channel N), bits 23:17 (masks, 1 = masked) and bit 16 (frequency select) from `wr_data`. It loads bit 0 (active) from `wr_data[0]`.
- R3: A byte write (`byte_wr_en`) loads bits 31:24 from `byte_data` and leaves all other bits unchanged.
- R4: Bits 9+2p:8+2p hold the mode of pair p, which covers channels 2p+1 and 2p. Mode codes: 00 independent, 01 parallel, 10 H-bridge, 11 reserved. A write changes this field only if both channel-on bits of the pair were 0 before the write. Otherwise the field keeps its old value.
- R5: Bits 7:1 are read-only flags. From bit 7 down they are over-temperature, over-current, open-load, hit-not-reached, plunger-movement, communication error and undervoltage. A write to these bits has no effect on them.
- R6: A pulse on `fault_evt[i]` sets flag bit i+1. A `flt_clr` pulse clears bits 7:2 but not undervoltage. A `rd_en` pulse does not clear bits 7:2. An event in the same cycle as its clear leaves the flag set.
- R7: A `rd_en` pulse clears the undervoltage flag (bit 1). An undervoltage event in the same cycle leaves it set.
- R8: `fault_n` is 0 exactly when some flag bit i+1 is 1 and its mask bit 17+i is 0.
- R9: `ch_en` equals bits 31:24 when the active bit is 1, and is 0 when the active bit is 0.
- R10: `resp_byte` is 0x04 while the communication error flag (bit 2) is set. Otherwise it equals bits 7:0.
- R11: When `wr_en` and `byte_wr_en` are both high in the same cycle, the channel-on byte takes its value from `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Full-word write strobe |
| wr_data | input | 32 | Full-word write data |
| byte_wr_en | input | 1 | Fast channel-on byte write strobe |
| byte_data | input | 8 | Channel-on byte data |
| rd_en | input | 1 | Read strobe of this word; clears undervoltage |
| flt_clr | input | 1 | Fault-register read strobe; clears flags 7:2 |
| fault_evt | input | 7 | Fault event pulses; bit i sets flag bit i+1 |
| rd_data | output | 32 | Current register contents |
| ch_en | output | 8 | Gated channel enables |
| fault_n | output | 1 | Active-low fault output |
| resp_byte | output | 8 | Fault byte for the serial response |

## Verification
A mode field that is written while its pair is on shows up in `rd_data` one clock after the write. It would also send a wrong pair configuration downstream. A flag that clears on the wrong strobe, or that loses a tie against its clear, shows up on `fault_n` and in `rd_data` bits 7:1 on the next clock edge. A mask bit stored in the wrong position moves the fault line in that same cycle. Both `ch_en` and `resp_byte` depend directly on the stored state, so a wrong active bit or communication error flag is visible at once, with no added latency.

// File: rtl/sdrv_pkg.sv
package sdrv_pkg;
  localparam int unsigned NUM_CH    = 8;
  localparam int unsigned NUM_PAIR  = NUM_CH / 2;
  localparam int unsigned FLAG_W    = 7;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned ONCH_LSB  = 24;
  localparam int unsigned MASK_LSB  = 17;
  localparam int unsigned FREQ_BIT  = 16;
  localparam int unsigned MODE_LSB  = 8;
  localparam int unsigned FLAG_LSB  = 1;
  localparam int unsigned COMER_IDX = 1;
  localparam int unsigned UVM_IDX   = 0;

  typedef enum logic [1:0] {
    PAIR_INDEP  = 2'b00,
    PAIR_PARAL  = 2'b01,
    PAIR_BRIDGE = 2'b10,
    PAIR_RSVD   = 2'b11
  } pair_mode_e;

  localparam logic [FLAG_W-1:0] FLAG_RST    = 7'b000_0001;
  localparam logic [FLAG_W-1:0] MASK_RST    = 7'b000_0010;
  localparam logic [FLAG_W-1:0] CLR_ON_READ = 7'b000_0001;
  localparam logic [7:0]        COMER_BYTE  = 8'h04;
endpackage

// File: rtl/sdrv_pair_cfg.sv
module sdrv_pair_cfg
  import sdrv_pkg::*;
#(
  parameter int unsigned CH = NUM_CH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CH-1:0] wr_onch,
  input  logic [CH-1:0] wr_mode,
  input  logic          byte_wr_en,
  input  logic [CH-1:0] byte_onch,
  output logic [CH-1:0] onch_q,
  output logic [CH-1:0] mode_q
);
  localparam int unsigned PAIRS = CH / 2;

  logic [CH-1:0] onch_d;
  logic          onch_ce;

  always_comb begin
    onch_ce = wr_en | byte_wr_en;
    onch_d  = onch_q;
    if (wr_en) onch_d = wr_onch;
    else if (byte_wr_en) onch_d = byte_onch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) onch_q <= '0;
    else if (onch_ce) onch_q <= onch_d;
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic       pair_idle;
    logic       mode_ce;
    logic [1:0] mode_d;

    always_comb begin
      pair_idle = ~(onch_q[2*p] | onch_q[2*p+1]);
      mode_ce   = wr_en & pair_idle;
      mode_d    = wr_mode[2*p +: 2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q[2*p +: 2] <= PAIR_INDEP;
      else if (mode_ce) mode_q[2*p +: 2] <= mode_d;
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (onch_q[2*p] | onch_q[2*p+1]) |=> $stable(mode_q[2*p +: 2])); // R4
  end
endmodule

// File: rtl/sdrv_flag_bank.sv
module sdrv_flag_bank
  import sdrv_pkg::*;
#(
  parameter int unsigned          W        = FLAG_W,
  parameter logic [FLAG_W-1:0]    RST_VAL  = FLAG_RST,
  parameter logic [FLAG_W-1:0]    RD_CLEAR = CLR_ON_READ
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         rd_en,
  input  logic         flt_clr,
  output logic [W-1:0] flag_q
);
  for (genvar i = 0; i < W; i++) begin : g_flag
    logic clr;
    logic flag_d;
    logic flag_ce;

    always_comb begin
      clr     = RD_CLEAR[i] ? rd_en : flt_clr;
      flag_ce = evt[i] | clr;
      flag_d  = evt[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= RST_VAL[i];
      else if (flag_ce) flag_q[i] <= flag_d;
    end

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flag_q[i]); // R6
  end
endmodule

// File: rtl/sdrv_fault_out.sv
module sdrv_fault_out
  import sdrv_pkg::*;
#(
  parameter int unsigned W = FLAG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] masks,
  input  logic         active,
  output logic         fault_n,
  output logic [7:0]   resp_byte
);
  logic [W-1:0] live;
  logic [7:0]   low_byte;

  always_comb begin
    live      = flags & ~masks;
    fault_n   = ~(|live);
    low_byte  = {flags, active};
    resp_byte = flags[COMER_IDX] ? COMER_BYTE : low_byte;
  end

  AST_FAULT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[UVM_IDX] & ~masks[UVM_IDX]) |-> !fault_n); // R8
endmodule

// File: rtl/sdrv_status_reg.sv
module sdrv_status_reg
  import sdrv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        byte_wr_en,
  input  logic [7:0]  byte_data,
  input  logic        rd_en,
  input  logic        flt_clr,
  input  logic [6:0]  fault_evt,
  output logic [31:0] rd_data,
  output logic [7:0]  ch_en,
  output logic        fault_n,
  output logic [7:0]  resp_byte
);
  logic [1:0]        rst_sync;
  logic              srst_n;
  logic [NUM_CH-1:0] onch_q;
  logic [NUM_CH-1:0] mode_q;
  logic [FLAG_W-1:0] flag_q;
  logic [FLAG_W-1:0] mask_q;
  logic [FLAG_W-1:0] mask_d;
  logic              freq_q;
  logic              freq_d;
  logic              act_q;
  logic              act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  sdrv_pair_cfg #(.CH(NUM_CH)) u_pair (
    .clk       (clk),
    .rst_n     (srst_n),
    .wr_en     (wr_en),
    .wr_onch   (wr_data[ONCH_LSB +: NUM_CH]),
    .wr_mode   (wr_data[MODE_LSB +: NUM_CH]),
    .byte_wr_en(byte_wr_en),
    .byte_onch (byte_data),
    .onch_q    (onch_q),
    .mode_q    (mode_q)
  );

  sdrv_flag_bank #(.W(FLAG_W), .RST_VAL(FLAG_RST), .RD_CLEAR(CLR_ON_READ)) u_flags (
    .clk    (clk),
    .rst_n  (srst_n),
    .evt    (fault_evt),
    .rd_en  (rd_en),
    .flt_clr(flt_clr),
    .flag_q (flag_q)
  );

  always_comb begin
    mask_d = wr_data[MASK_LSB +: FLAG_W];
    freq_d = wr_data[FREQ_BIT];
    act_d  = wr_data[0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mask_q <= MASK_RST;
      freq_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (wr_en) begin
      mask_q <= mask_d;
      freq_q <= freq_d;
      act_q  <= act_d;
    end
  end

  sdrv_fault_out #(.W(FLAG_W)) u_fout (
    .clk      (clk),
    .rst_n    (srst_n),
    .flags    (flag_q),
    .masks    (mask_q),
    .active   (act_q),
    .fault_n  (fault_n),
    .resp_byte(resp_byte)
  );

  always_comb begin
    rd_data = {onch_q, mask_q, freq_q, mode_q, flag_q, act_q};
    ch_en   = act_q ? onch_q : '0;
  end

  AST_RO_FLAGS: assert property (@(posedge clk) disable iff (!srst_n)
    (!(|fault_evt) && !rd_en && !flt_clr) |=> $stable(flag_q)); // R5
  AST_UVM_CLEAR: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_en && !fault_evt[UVM_IDX]) |=> !flag_q[UVM_IDX]); // R7
endmodule

// File: tb/sdrv_status_reg_tb_top.sv
module sdrv_status_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, byte_wr_en, rd_en, flt_clr;
  logic [31:0] wr_data;
  logic [7:0]  byte_data;
  logic [6:0]  fault_evt;
  logic [31:0] rd_data;
  logic [7:0]  ch_en, resp_byte;
  logic        fault_n;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #4 clk = ~clk;

  sdrv_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .byte_wr_en(byte_wr_en), .byte_data(byte_data), .rd_en(rd_en),
    .flt_clr(flt_clr), .fault_evt(fault_evt), .rd_data(rd_data),
    .ch_en(ch_en), .fault_n(fault_n), .resp_byte(resp_byte)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; byte_wr_en = 0; rd_en = 0; flt_clr = 0; fault_evt = '0;
  endtask

  // Drive for one edge from a negedge, then return at the following negedge.
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic do_write(input logic [31:0] d);
    wr_en = 1; wr_data = d; step();
  endtask

  task automatic t_reset();
    chk("R1 word", rd_data, 32'h0004_0002);
    chk("R1 fault_n", {31'd0, fault_n}, 32'd0);
    chk("R1 ch_en", {24'd0, ch_en}, 32'd0);
    chk("R10 resp", {24'd0, resp_byte}, 32'h02);
  endtask

  task automatic t_read_clear();
    rd_en = 1; step();
    chk("R7 uvm cleared", rd_data, 32'h0004_0000);
    chk("R8 fault released", {31'd0, fault_n}, 32'd1);
  endtask

  task automatic t_full_write();
    do_write(32'hA501_E4FF);
    chk("R2/R4/R5 word", rd_data, 32'hA501_E401);
    chk("R9 ch_en active", {24'd0, ch_en}, 32'hA5);
  endtask

  task automatic t_byte_and_guard();
    byte_wr_en = 1; byte_data = 8'h0C; step();
    chk("R3 byte write", rd_data, 32'h0C01_E401);
    do_write(32'h0C01_1B01);
    chk("R4 guarded pair", rd_data, 32'h0C01_1701);
  endtask

  task automatic t_inactive();
    do_write(32'h0C01_1700);
    chk("R9 ch_en off", {24'd0, ch_en}, 32'h00);
    chk("R9 word", rd_data, 32'h0C01_1700);
  endtask

  task automatic t_flags();
    fault_evt = 7'b010_0000; step();
    chk("R6 ocp set", rd_data[7:0], 32'h40);
    chk("R8 fault low", {31'd0, fault_n}, 32'd0);
    do_write(32'h0C01_17FE);
    chk("R5 ro flags", rd_data, 32'h0C01_1740);
    rd_en = 1; step();
    chk("R6 read keeps ocp", rd_data[7:0], 32'h40);
    flt_clr = 1; step();
    chk("R6 clr", rd_data[7:0], 32'h00);
    chk("R8 released", {31'd0, fault_n}, 32'd1);
  endtask

  task automatic t_mask();
    do_write(32'h0C41_1700);
    fault_evt = 7'b010_0000; step();
    chk("R8 masked word", rd_data, 32'h0C41_1740);
    chk("R8 masked fault_n", {31'd0, fault_n}, 32'd1);
    flt_clr = 1; fault_evt = 7'b010_0000; step();
    chk("R6 event wins", rd_data[7:0], 32'h40);
    flt_clr = 1; step();
    chk("R6 cleared after tie", rd_data[7:0], 32'h00);
  endtask

  task automatic t_comer();
    fault_evt = 7'b100_0010; step();
    chk("R10 comer byte", {24'd0, resp_byte}, 32'h04);
    chk("R6 low byte", rd_data[7:0], 32'h84);
    chk("R8 ovt unmasked", {31'd0, fault_n}, 32'd0);
    flt_clr = 1; step();
    chk("R10 normal byte", {24'd0, resp_byte}, 32'h00);
  endtask

  task automatic t_uvm_tie();
    rd_en = 1; fault_evt = 7'b000_0001; step();
    chk("R7 event wins", rd_data[7:0], 32'h02);
    chk("R8 uvm fault", {31'd0, fault_n}, 32'd0);
    rd_en = 1; step();
    chk("R7 cleared", rd_data[7:0], 32'h00);
  endtask

  task automatic t_both_writes();
    wr_en = 1; wr_data = 32'h3341_1700; byte_wr_en = 1; byte_data = 8'hCC; step();
    chk("R11 full write wins", rd_data, 32'h3341_1700);
  endtask

  initial begin
    idle(); wr_data = '0; byte_data = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read_clear();
    t_full_write();
    t_byte_and_guard();
    t_inactive();
    t_flags();
    t_mask();
    t_comer();
    t_uvm_tie();
    t_both_writes();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule